// File: doc/BRIEF.md
# Remote DMA Data Port

This block is the host-side data port of a packet buffer. The host reads or writes the packet memory through one port. A remote address register steps forward on its own after every access. A remaining-byte counter counts down with each access and raises a one-cycle completion pulse when it is used up. When the address reaches the ring stop page, it reloads from the ring start page.

Each access moves 1, 2 or 4 bytes in little-endian lane order. A 4-byte host access always moves four bytes. For a narrower access, a configuration input selects whether it moves one byte or a 16-bit word. Only two windows of the address space hold storage: the identity PROM below address 32, and the packet window. The PROM is filled at reset from a MAC address parameter. The surrounding logic loads the address and count through a load strobe, and supplies the ring start and stop pages and the width bit as plain inputs.

Top module: `rdma_port`

## Requirements
- R1: The access length is 4 bytes when `hostSize` is 3. For any other `hostSize` it is 2 bytes when `cfgWide` is 1 and 1 byte when `cfgWide` is 0. An accepted access advances `curAddr` by that length.
- R2: If `curAddr` plus the length equals `ringStopPg`*256, the new address is `ringStartPg`*256 instead.
- R3: If `remCount` is at most the length, it becomes 0 and `dmaDone` is 1 for exactly one cycle. Otherwise `remCount` drops by the length and `dmaDone` stays 0.
- R4: A write while `remCount` is 0 is ignored: no memory byte, `curAddr`, `remCount` or `dmaDone` changes. A read while `remCount` is 0 still goes ahead.
- R5: For 2- and 4-byte accesses, address bit 0 is treated as 0 when memory is addressed. Byte k of the access sits at bits [8k+7:8k] of `rdData` and `hostWdata`. `curAddr` still advances from its unaligned value.
- R6: A byte is backed by storage only if its address is below 32 or inside [0x4000, 0x4000+PKT_BYTES). Other bytes read as 0xFF and ignore writes. `curAddr` and `remCount` update as usual.
- R7: Reset sets `curAddr`, `remCount`, `rdData`, `rdValid` and `dmaDone` to 0. It also fills PROM addresses 2i and 2i+1 with PROM byte i, for i from 0 to 15. PROM bytes 0..5 are the MAC (most significant byte first), bytes 14 and 15 are 0x57, and the rest are 0.
- R8: Read data and `rdValid` appear in the cycle after the strobe cycle, and `rdValid` is high only then. The `curAddr`, `remCount` and `dmaDone` results of an access appear in that same following cycle.
- R9: `ldStb` loads `ldAddr` and `ldCount`. If a host strobe arrives in the same cycle, the load wins and the strobe is dropped.
- R10: Read lanes beyond the access length return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| hostStb | input | 1 | Host access strobe, one access per cycle |
| hostWr | input | 1 | 1 = write, 0 = read |
| hostSize | input | 2 | Host size; 3 = 4-byte access, other values = narrow |
| hostWdata | input | 32 | Write data, little-endian lanes |
| cfgWide | input | 1 | Narrow accesses move 2 bytes when set |
| ringStartPg | input | 8 | Ring start page |
| ringStopPg | input | 8 | Ring stop page |
| ldStb | input | 1 | Load address and count |
| ldAddr | input | 16 | Address to load |
| ldCount | input | 16 | Byte count to load |
| rdData | output | 32 | Read data |
| rdValid | output | 1 | Read data valid |
| curAddr | output | 16 | Current remote address |
| remCount | output | 16 | Remaining byte count |
| dmaDone | output | 1 | Count-exhausted pulse |

## Verification
Every result of an access is due exactly one clock after the strobe edge. This covers read data, `rdValid`, the stepped address, the reduced count and the completion pulse. The bench drives each access on a falling edge and samples one time unit after the next rising edge. The completion pulse is checked again one clock later, where it must have dropped. An ignored write is confirmed in two ways: the address and count are sampled right after it, and a read from count zero shows the old memory contents.

// File: rtl/rdma_pkg.sv
package rdma_pkg;
  parameter int unsigned RDMA_AW = 16;

  typedef enum logic [1:0] {
    XFER_BYTE = 2'd0,
    XFER_WORD = 2'd1,
    XFER_LONG = 2'd2
  } xferWidth_e;

  typedef struct packed {
    logic               rdEn;
    logic               wrEn;
    xferWidth_e         width;
    logic [RDMA_AW-1:0] memAddr;
  } memCmd_t;

  function automatic logic [2:0] xferBytes(input xferWidth_e w);
    case (w)
      XFER_LONG: return 3'd4;
      XFER_WORD: return 3'd2;
      default:   return 3'd1;
    endcase
  endfunction
endpackage

// File: rtl/rdma_ctrl.sv
module rdma_ctrl
  import rdma_pkg::*;
#(
  parameter int unsigned AW = RDMA_AW,
  parameter int unsigned CW = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            hostStb,
  input  logic            hostWr,
  input  logic [1:0]      hostSize,
  input  logic            cfgWide,
  input  logic [AW-9:0]   ringStartPg,
  input  logic [AW-9:0]   ringStopPg,
  input  logic            ldStb,
  input  logic [AW-1:0]   ldAddr,
  input  logic [CW-1:0]   ldCount,
  output memCmd_t         cmd,
  output logic [AW-1:0]   curAddr,
  output logic [CW-1:0]   remCount,
  output logic            dmaDone
);
  localparam int unsigned PG_W = AW - 8;

  xferWidth_e    width;
  logic [2:0]    nBytes;
  logic          blocked;
  logic          take;
  logic [AW-1:0] stepAddr;
  logic [AW-1:0] nextAddr;
  logic          lastXfer;

  always_comb begin
    if (hostSize == 2'd3)  width = XFER_LONG;
    else if (cfgWide)      width = XFER_WORD;
    else                   width = XFER_BYTE;
    nBytes   = xferBytes(width);
    blocked  = hostWr && (remCount == '0);
    take     = hostStb && !ldStb && !blocked;
    stepAddr = curAddr + AW'(nBytes);
    if (stepAddr == {ringStopPg, 8'h00}) nextAddr = {ringStartPg, 8'h00};
    else                                 nextAddr = stepAddr;
    lastXfer = remCount <= CW'(nBytes);
  end

  always_comb begin
    cmd.rdEn  = take && !hostWr;
    cmd.wrEn  = take && hostWr;
    cmd.width = width;
    if (width == XFER_BYTE) cmd.memAddr = curAddr;
    else                    cmd.memAddr = {curAddr[AW-1:1], 1'b0};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr  <= '0;
      remCount <= '0;
      dmaDone  <= 1'b0;
    end else if (ldStb) begin
      curAddr  <= ldAddr;
      remCount <= ldCount;
      dmaDone  <= 1'b0;
    end else if (take) begin
      curAddr  <= nextAddr;
      remCount <= lastXfer ? '0 : remCount - CW'(nBytes);
      dmaDone  <= lastXfer;
    end else begin
      dmaDone  <= 1'b0;
    end
  end

  logic unusedPg;
  assign unusedPg = ^{PG_W};
endmodule

// File: rtl/rdma_datapath.sv
module rdma_datapath
  import rdma_pkg::*;
#(
  parameter int unsigned AW         = RDMA_AW,
  parameter int unsigned PROM_SPAN  = 32,
  parameter int unsigned PKT_BASE   = 16'h4000,
  parameter int unsigned PKT_BYTES  = 2048,
  parameter logic [47:0] MAC_ADDR   = 48'h02_11_22_33_44_55
) (
  input  logic        clk,
  input  logic        rstN,
  input  memCmd_t     cmd,
  input  logic [31:0] hostWdata,
  output logic [31:0] rdData,
  output logic        rdValid
);
  localparam int unsigned STORE = PROM_SPAN + PKT_BYTES;
  localparam int unsigned IW    = $clog2(STORE);
  localparam int unsigned LANES = 4;
  localparam logic [AW-1:0] PROM_END = AW'(PROM_SPAN);
  localparam logic [AW-1:0] PKT_LO   = AW'(PKT_BASE);
  localparam logic [AW-1:0] PKT_HI   = AW'(PKT_BASE + PKT_BYTES);

  logic [7:0]    store [STORE];
  logic [2:0]    nBytes;
  logic [LANES-1:0] laneHit;
  logic [LANES-1:0] laneOn;
  logic [IW-1:0] laneIdx [LANES];

  assign nBytes = xferBytes(cmd.width);

  function automatic logic [7:0] promByte(input int unsigned loc);
    int unsigned slot;
    slot = loc / 2;
    if (slot < 6)                    return MAC_ADDR[47 - 8*slot -: 8];
    else if (slot == 14 || slot == 15) return 8'h57;
    else                             return 8'h00;
  endfunction

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [AW-1:0] laneAddr;
    logic [AW-1:0] laneOff;
    assign laneAddr   = cmd.memAddr + AW'(k);
    assign laneHit[k] = (laneAddr < PROM_END) ||
                        ((laneAddr >= PKT_LO) && (laneAddr < PKT_HI));
    assign laneOff    = (laneAddr < PROM_END) ? laneAddr
                                              : laneAddr - PKT_LO + PROM_END;
    assign laneIdx[k] = laneOff[IW-1:0];
    assign laneOn[k]  = 3'(k) < nBytes;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < PROM_SPAN; i++) store[i] <= promByte(i);
    end else if (cmd.wrEn) begin
      for (int k = 0; k < LANES; k++)
        if (laneOn[k] && laneHit[k]) store[laneIdx[k]] <= hostWdata[8*k +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= cmd.rdEn;
      if (cmd.rdEn) begin
        for (int k = 0; k < LANES; k++) begin
          if (!laneOn[k])      rdData[8*k +: 8] <= 8'h00;
          else if (laneHit[k]) rdData[8*k +: 8] <= store[laneIdx[k]];
          else                 rdData[8*k +: 8] <= 8'hFF;
        end
      end
    end
  end
endmodule

// File: rtl/rdma_port.sv
module rdma_port
  import rdma_pkg::*;
#(
  parameter int unsigned AW        = RDMA_AW,
  parameter int unsigned CW        = 16,
  parameter int unsigned PKT_BASE  = 16'h4000,
  parameter int unsigned PKT_BYTES = 2048,
  parameter logic [47:0] MAC_ADDR  = 48'h02_11_22_33_44_55
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          hostStb,
  input  logic          hostWr,
  input  logic [1:0]    hostSize,
  input  logic [31:0]   hostWdata,
  input  logic          cfgWide,
  input  logic [7:0]    ringStartPg,
  input  logic [7:0]    ringStopPg,
  input  logic          ldStb,
  input  logic [15:0]   ldAddr,
  input  logic [15:0]   ldCount,
  output logic [31:0]   rdData,
  output logic          rdValid,
  output logic [15:0]   curAddr,
  output logic [15:0]   remCount,
  output logic          dmaDone
);
  memCmd_t cmd;

  rdma_ctrl #(.AW(AW), .CW(CW)) u_ctrl (
    .clk(clk), .rstN(rstN), .hostStb(hostStb), .hostWr(hostWr),
    .hostSize(hostSize), .cfgWide(cfgWide), .ringStartPg(ringStartPg),
    .ringStopPg(ringStopPg), .ldStb(ldStb), .ldAddr(ldAddr),
    .ldCount(ldCount), .cmd(cmd), .curAddr(curAddr),
    .remCount(remCount), .dmaDone(dmaDone)
  );

  rdma_datapath #(
    .AW(AW), .PROM_SPAN(32), .PKT_BASE(PKT_BASE),
    .PKT_BYTES(PKT_BYTES), .MAC_ADDR(MAC_ADDR)
  ) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .hostWdata(hostWdata),
    .rdData(rdData), .rdValid(rdValid)
  );
endmodule

// File: rtl/rdma_port_chk.sv
module rdma_port_chk (
  input logic        clk,
  input logic        rstN,
  input logic        hostStb,
  input logic        hostWr,
  input logic [1:0]  hostSize,
  input logic        cfgWide,
  input logic        ldStb,
  input logic [15:0] ldAddr,
  input logic [15:0] ldCount,
  input logic [31:0] rdData,
  input logic        rdValid,
  input logic [15:0] curAddr,
  input logic [15:0] remCount,
  input logic        dmaDone
);
  logic rdTake;
  assign rdTake = hostStb && !hostWr && !ldStb;

  p_load_r9: assert property (@(posedge clk) disable iff (!rstN)
    ldStb |=> (curAddr == $past(ldAddr)) && (remCount == $past(ldCount)));

  p_ignore_r4: assert property (@(posedge clk) disable iff (!rstN)
    (hostStb && hostWr && !ldStb && remCount == 16'd0)
      |=> ($stable(curAddr) && $stable(remCount) && !dmaDone));

  p_done_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    dmaDone |-> (remCount == 16'd0));

  p_rd_valid_r8: assert property (@(posedge clk) disable iff (!rstN)
    rdTake |=> rdValid);

  p_rd_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    !rdTake |=> !rdValid);

  p_zero_fill_r10: assert property (@(posedge clk) disable iff (!rstN)
    (rdTake && hostSize != 2'd3 && !cfgWide) |=> (rdData[31:8] == 24'd0));

  p_long_step_r1: assert property (@(posedge clk) disable iff (!rstN)
    (hostStb && !ldStb && hostSize == 2'd3 && remCount > 16'd4)
      |=> (remCount == $past(remCount) - 16'd4));
endmodule

bind rdma_port rdma_port_chk u_chk (.*);

// File: tb/sim_rdma_port.sv
module sim_rdma_port;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostStb = 1'b0;
  logic        hostWr = 1'b0;
  logic [1:0]  hostSize = 2'd0;
  logic [31:0] hostWdata = '0;
  logic        cfgWide = 1'b0;
  logic [7:0]  ringStartPg = 8'h40;
  logic [7:0]  ringStopPg = 8'h48;
  logic        ldStb = 1'b0;
  logic [15:0] ldAddr = '0;
  logic [15:0] ldCount = '0;
  logic [31:0] rdData;
  logic        rdValid;
  logic [15:0] curAddr;
  logic [15:0] remCount;
  logic        dmaDone;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  rdma_port u0 (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load(input logic [15:0] a, input logic [15:0] c);
    @(negedge clk);
    ldStb = 1'b1; ldAddr = a; ldCount = c;
    @(posedge clk); #1;
    ldStb = 1'b0;
  endtask

  task automatic access(input logic wr, input logic [1:0] sz, input logic [31:0] wd);
    @(negedge clk);
    hostStb = 1'b1; hostWr = wr; hostSize = sz; hostWdata = wd;
    @(posedge clk); #1;
    hostStb = 1'b0;
  endtask

  task automatic t_reset;
    check("R7 addr", 32'(curAddr), 32'h0);
    check("R7 count", 32'(remCount), 32'h0);
    check("R7 valid", 32'(rdValid), 32'h0);
    check("R7 done", 32'(dmaDone), 32'h0);
    cfgWide = 1'b0;
    load(16'h0000, 16'd32);
    access(1'b0, 2'd0, '0);
    check("R7 prom0", rdData, 32'h02);
    access(1'b0, 2'd0, '0);
    check("R7 prom dup", rdData, 32'h02);
    access(1'b0, 2'd0, '0);
    check("R7 prom2", rdData, 32'h11);
    load(16'd28, 16'd4);
    access(1'b0, 2'd0, '0);
    check("R7 prom 0x57", rdData, 32'h57);
    load(16'd12, 16'd4);
    access(1'b0, 2'd0, '0);
    check("R7 prom zero", rdData, 32'h00);
  endtask

  task automatic t_lanes;
    load(16'h4000, 16'd16);
    access(1'b1, 2'd3, 32'hDDCCBBAA);
    check("R1 long step", 32'(curAddr), 32'h4004);
    check("R3 count sub", 32'(remCount), 32'd12);
    load(16'h4000, 16'd8);
    cfgWide = 1'b0;
    access(1'b0, 2'd0, '0);
    check("R5 lane0", rdData, 32'hAA);
    check("R1 byte step", 32'(curAddr), 32'h4001);
    cfgWide = 1'b1;
    access(1'b0, 2'd1, '0);
    check("R5 align word", rdData, 32'h0000BBAA);
    check("R5 unaligned step", 32'(curAddr), 32'h4003);
    load(16'h4001, 16'd8);
    access(1'b0, 2'd3, '0);
    check("R5 long lanes", rdData, 32'hDDCCBBAA);
    cfgWide = 1'b0;
    load(16'h4002, 16'd8);
    access(1'b1, 2'd0, 32'h00000077);
    check("R1 byte write step", 32'(curAddr), 32'h4003);
    load(16'h4000, 16'd8);
    access(1'b0, 2'd3, '0);
    check("R1 byte write lands", rdData, 32'hDD77BBAA);
  endtask

  task automatic t_window;
    load(16'h2000, 16'd8);
    access(1'b0, 2'd3, '0);
    check("R6 hole read", rdData, 32'hFFFFFFFF);
    check("R6 addr updates", 32'(curAddr), 32'h2004);
    check("R6 count updates", 32'(remCount), 32'd4);
    cfgWide = 1'b0;
    access(1'b0, 2'd0, '0);
    check("R10 byte zero fill", rdData, 32'h000000FF);
    load(16'h2000, 16'd4);
    access(1'b1, 2'd3, 32'h11111111);
    load(16'h2000, 16'd4);
    access(1'b0, 2'd3, '0);
    check("R6 hole write dropped", rdData, 32'hFFFFFFFF);
  endtask

  task automatic t_count;
    cfgWide = 1'b1;
    load(16'h4000, 16'd3);
    access(1'b1, 2'd1, 32'h1234);
    check("R3 partial count", 32'(remCount), 32'd1);
    check("R3 no done", 32'(dmaDone), 32'h0);
    access(1'b1, 2'd1, 32'h5678);
    check("R3 count zero", 32'(remCount), 32'd0);
    check("R3 done pulse", 32'(dmaDone), 32'h1);
    @(posedge clk); #1;
    check("R3 done one cycle", 32'(dmaDone), 32'h0);
    load(16'h4000, 16'd0);
    access(1'b1, 2'd3, 32'hFFFFFFFF);
    check("R4 addr held", 32'(curAddr), 32'h4000);
    check("R4 count held", 32'(remCount), 32'd0);
    check("R4 no done", 32'(dmaDone), 32'h0);
    access(1'b0, 2'd3, '0);
    check("R4 memory kept", rdData, 32'h56781234);
    check("R4 read at zero done", 32'(dmaDone), 32'h1);
    check("R4 read at zero step", 32'(curAddr), 32'h4004);
  endtask

  task automatic t_wrap;
    cfgWide = 1'b1;
    ringStartPg = 8'h40; ringStopPg = 8'h41;
    load(16'h40FE, 16'd10);
    access(1'b0, 2'd1, '0);
    check("R2 word wrap", 32'(curAddr), 32'h4000);
    load(16'h40FC, 16'd10);
    access(1'b0, 2'd3, '0);
    check("R2 long wrap", 32'(curAddr), 32'h4000);
    ringStopPg = 8'h42;
    load(16'h40FE, 16'd10);
    access(1'b0, 2'd1, '0);
    check("R2 no wrap", 32'(curAddr), 32'h4100);
  endtask

  task automatic t_timing;
    load(16'h4000, 16'd8);
    check("R8 idle valid", 32'(rdValid), 32'h0);
    access(1'b0, 2'd1, '0);
    check("R8 valid next", 32'(rdValid), 32'h1);
    @(posedge clk); #1;
    check("R8 valid one cycle", 32'(rdValid), 32'h0);
    @(negedge clk);
    hostStb = 1'b1; hostWr = 1'b0; hostSize = 2'd3;
    ldStb = 1'b1; ldAddr = 16'h4010; ldCount = 16'd5;
    @(posedge clk); #1;
    hostStb = 1'b0; ldStb = 1'b0;
    check("R9 load addr", 32'(curAddr), 32'h4010);
    check("R9 load count", 32'(remCount), 32'd5);
    check("R9 strobe dropped", 32'(rdValid), 32'h0);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    #1;
    t_reset();
    t_lanes();
    t_window();
    t_count();
    t_wrap();
    t_timing();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule